// File: doc/BRIEF.md
# Early Branch Resolution and Next-PC Unit

This block produces the fetch address for a five-stage in-order pipeline and decides conditional branches while they are still in the decode stage. It holds the program counter and the fetch-to-decode pipeline register. A small equality comparator looks at the two register operands read in decode. These operands are already forwarded by an outside hazard unit. Together with the decoded branch kind and a jump flag, the comparator result chooses the address fetched on the next clock.

Branches and jumps use one architectural delay slot. The instruction fetched in the same cycle that a branch or jump sits in decode always goes on into decode. Nothing is ever squashed. A taken branch or jump therefore changes only the address of the fetch after the delay slot, and a branch that is not taken costs no cycle at all. An outside stall input freezes the PC and the decode register. A redirect that is due during a stall is held off until the stall ends.

Top module: `br_early_unit`

## Requirements
- R1: When `dec_is_branch_i` is high and `dec_branch_ne_i` is low (equal test), and the stall is low, `redirect_o` is high exactly when `opnd_a_i` equals `opnd_b_i`.
- R2: When `dec_is_branch_i` and `dec_branch_ne_i` are both high (not-equal test), and the stall is low, `redirect_o` is high exactly when the operands differ.
- R3: For a taken branch, the PC on the next clock is `fd_pc_o + 4` plus the 16-bit `dec_offset_i`, sign-extended and shifted left by two.
- R4: When `dec_is_jump_i` is high and the stall is low, `redirect_o` is high and the PC on the next clock is `dec_jump_target_i`. The jump takes precedence over a branch flagged in the same cycle.
- R5: With no redirect and no stall, the PC advances by exactly 4 on every clock.
- R6: On every clock without a stall, the decode register takes the word on `fetch_instr_i` and `fd_pc_o` takes the old PC. This includes the delay-slot word fetched while a branch or jump is in decode.
- R7: While `stall_i` is high, `pc_o`, `fd_instr_o` and `fd_pc_o` hold, `redirect_o` is low and `next_pc_o` equals `pc_o`. A branch still in decode when the stall drops redirects at that point.
- R8: Reset (`rst_n` low) sets `pc_o`, `fd_pc_o` and `fd_instr_o` to zero. The all-zero word is the no-op.
- R9: `next_pc_o` always equals the value `pc_o` takes at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold PC and decode register this cycle |
| fetch_instr_i | input | 32 | Instruction word read at `pc_o` |
| dec_is_branch_i | input | 1 | Decode holds a conditional branch |
| dec_branch_ne_i | input | 1 | Branch condition: 0 = equal, 1 = not equal |
| dec_is_jump_i | input | 1 | Decode holds an unconditional jump |
| dec_offset_i | input | 16 | Signed word offset of the branch |
| dec_jump_target_i | input | 32 | Jump destination address |
| opnd_a_i | input | 32 | First forwarded register operand |
| opnd_b_i | input | 32 | Second forwarded register operand |
| pc_o | output | 32 | Current fetch address |
| next_pc_o | output | 32 | Address loaded into the PC at the next clock |
| redirect_o | output | 1 | Fetch leaves the sequential path at the next clock |
| fd_instr_o | output | 32 | Instruction held in decode |
| fd_pc_o | output | 32 | Address of the instruction held in decode |

## Verification
Directed cycles first pair each branch test with equal and with unequal operands. A wrong polarity or a comparator stuck at one answer cannot pass both halves. A jump is raised together with a branch of a different target, which shows whether precedence is right. A taken branch is also held under a multi-cycle stall, which shows that the redirect is deferred rather than lost or fired early. A long random run then mixes negative and positive offsets, operand pairs that often match or differ in one slice, and sparse stalls. A behavioural model is compared with every output on every cycle, so target arithmetic and delay-slot capture are checked across many PCs.

// File: rtl/br_early_pkg.sv
package br_early_pkg;

  parameter int XLEN   = 32;
  parameter int OFF_W  = 16;
  parameter int STEP   = 4;

  localparam int EXT_W = XLEN - OFF_W - 2;

  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2,
    FLOW_HOLD   = 2'd3
  } flow_e;

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    seq_addr = pc + XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] word_offset(input logic [OFF_W-1:0] off);
    word_offset = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  endfunction

  // target relative to the delay-slot address
  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] br_pc,
                                                  input logic [OFF_W-1:0] off);
    branch_dest = seq_addr(br_pc) + word_offset(off);
  endfunction

endpackage

// File: rtl/br_early_cmp.sv
module br_early_cmp
  import br_early_pkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int SLICE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             is_branch_i,
  input  logic             test_ne_i,
  output logic             cond_hit_o
);

  localparam int NSLICE = (WIDTH + SLICE - 1) / SLICE;
  localparam int PADW   = NSLICE * SLICE;

  logic [PADW-1:0]   a_pad, b_pad;
  logic [NSLICE-1:0] slice_eq;
  logic              ops_equal;

  assign a_pad = PADW'(a_i);
  assign b_pad = PADW'(b_i);

  // equality split into slices reduced by an AND tree
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slice_eq[s] = (a_pad[s*SLICE +: SLICE] == b_pad[s*SLICE +: SLICE]);
  end

  assign ops_equal  = &slice_eq;
  assign cond_hit_o = is_branch_i & (test_ne_i ? ~ops_equal : ops_equal);

  assert_eq_test_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch_i && !test_ne_i) |-> (cond_hit_o == (a_i === b_i)));

  assert_ne_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch_i && test_ne_i) |-> (cond_hit_o == (a_i !== b_i)));

endmodule

// File: rtl/br_early_nextpc.sv
module br_early_nextpc
  import br_early_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  fd_pc_i,
  input  logic             cond_hit_i,
  input  logic             is_jump_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  jump_target_i,
  output flow_e            flow_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  next_pc_o
);

  logic [XLEN-1:0] br_dest;

  assign br_dest = branch_dest(fd_pc_i, offset_i);

  always_comb begin
    if (stall_i)         flow_o = FLOW_HOLD;
    else if (is_jump_i)  flow_o = FLOW_JUMP;
    else if (cond_hit_i) flow_o = FLOW_BRANCH;
    else                 flow_o = FLOW_SEQ;
  end

  always_comb begin
    unique case (flow_o)
      FLOW_HOLD:   next_pc_o = pc_i;
      FLOW_JUMP:   next_pc_o = jump_target_i;
      FLOW_BRANCH: next_pc_o = br_dest;
      default:     next_pc_o = seq_addr(pc_i);
    endcase
  end

  assign redirect_o = (flow_o == FLOW_JUMP) || (flow_o == FLOW_BRANCH);

  assert_jump_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump_i && !stall_i) |-> (redirect_o && next_pc_o == jump_target_i));

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (!redirect_o && next_pc_o == pc_i));

endmodule

// File: rtl/br_early_fetchregs.sv
module br_early_fetchregs
  import br_early_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [XLEN-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic [XLEN-1:0] fetch_instr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] fd_instr_o,
  output logic [XLEN-1:0] fd_pc_o
);

  logic [XLEN-1:0] pc_q, fd_instr_q, fd_pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      fd_instr_q <= NOP_WORD;
      fd_pc_q    <= RESET_PC;
    end else if (!stall_i) begin
      pc_q       <= next_pc_i;
      fd_instr_q <= fetch_instr_i;
      fd_pc_q    <= pc_q;
    end
  end

  assign pc_o       = pc_q;
  assign fd_instr_o = fd_instr_q;
  assign fd_pc_o    = fd_pc_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(pc_q) && $stable(fd_instr_q) && $stable(fd_pc_q)));

  assert_slot_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> (fd_pc_q == $past(pc_q) && fd_instr_q == $past(fetch_instr_i)));

endmodule

// File: rtl/br_early_unit.sv
module br_early_unit
  import br_early_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall_i,
  input  logic [31:0] fetch_instr_i,
  input  logic        dec_is_branch_i,
  input  logic        dec_branch_ne_i,
  input  logic        dec_is_jump_i,
  input  logic [15:0] dec_offset_i,
  input  logic [31:0] dec_jump_target_i,
  input  logic [31:0] opnd_a_i,
  input  logic [31:0] opnd_b_i,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o,
  output logic        redirect_o,
  output logic [31:0] fd_instr_o,
  output logic [31:0] fd_pc_o
);

  logic  cond_hit_w;
  flow_e flow_w;

  br_early_cmp #(.WIDTH(XLEN), .SLICE(8)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_i         (opnd_a_i),
    .b_i         (opnd_b_i),
    .is_branch_i (dec_is_branch_i),
    .test_ne_i   (dec_branch_ne_i),
    .cond_hit_o  (cond_hit_w)
  );

  br_early_nextpc u_next (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .pc_i          (pc_o),
    .fd_pc_i       (fd_pc_o),
    .cond_hit_i    (cond_hit_w),
    .is_jump_i     (dec_is_jump_i),
    .offset_i      (dec_offset_i),
    .jump_target_i (dec_jump_target_i),
    .flow_o        (flow_w),
    .redirect_o    (redirect_o),
    .next_pc_o     (next_pc_o)
  );

  br_early_fetchregs #(.RESET_PC('0), .NOP_WORD('0)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .next_pc_i     (next_pc_o),
    .fetch_instr_i (fetch_instr_i),
    .pc_o          (pc_o),
    .fd_instr_o    (fd_instr_o),
    .fd_pc_o       (fd_pc_o)
  );

  assert_next_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pc_o == $past(next_pc_o)));

  assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redirect_o) |=> (pc_o == $past(pc_o) + 32'd4));

  assert_branch_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_w == FLOW_BRANCH) |=>
      (pc_o == $past(fd_pc_o) + 32'd4 + {{14{$past(dec_offset_i[15])}}, $past(dec_offset_i), 2'b00}));

endmodule

// File: tb/br_early_unit_test.sv
`timescale 1ns/1ps
module br_early_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0;
  logic [31:0] fetch_instr_i;
  logic        dec_is_branch_i = 1'b0, dec_branch_ne_i = 1'b0, dec_is_jump_i = 1'b0;
  logic [15:0] dec_offset_i = '0;
  logic [31:0] dec_jump_target_i = '0, opnd_a_i = '0, opnd_b_i = '0;
  logic [31:0] pc_o, next_pc_o, fd_instr_o, fd_pc_o;
  logic        redirect_o;

  always #2.5 clk = ~clk;

  br_early_unit uut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  assign fetch_instr_i = mem_word(pc_o);

  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_pc = 0, m_fdi = 0, m_fdp = 0;
  int last_kind = 2; // 0 hold, 1 redirect, 2 sequential

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit br, input bit ne, input bit jmp, input logic [15:0] off,
                      input logic [31:0] jt, input logic [31:0] a, input logic [31:0] b,
                      input bit st);
    bit          take;
    logic [31:0] tgt, nxt;
    string       rtag;
    chk(last_kind == 0 ? "R7 pc" : (last_kind == 1 ? "R3 pc" : "R5 pc"), pc_o, m_pc);
    chk("R6 fd_instr", fd_instr_o, m_fdi);
    chk("R6 fd_pc", fd_pc_o, m_fdp);
    dec_is_branch_i = br; dec_branch_ne_i = ne; dec_is_jump_i = jmp;
    dec_offset_i = off; dec_jump_target_i = jt; opnd_a_i = a; opnd_b_i = b; stall_i = st;
    #1;
    take = !st && (jmp || (br && (ne ? (a != b) : (a == b))));
    if (jmp) tgt = jt;
    else     tgt = m_fdp + 4 + (32'(signed'(off)) * 4);
    nxt = st ? m_pc : (take ? tgt : m_pc + 4);
    rtag = st ? "R7 redirect" : (jmp ? "R4 redirect" : (ne ? "R2 redirect" : "R1 redirect"));
    chk(rtag, {31'd0, redirect_o}, {31'd0, take});
    chk("R9 next_pc", next_pc_o, nxt);
    @(posedge clk);
    if (!st) begin
      m_fdi = mem_word(m_pc);
      m_fdp = m_pc;
      m_pc  = nxt;
    end
    last_kind = st ? 0 : (take ? 1 : 2);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 pc", pc_o, 32'd0);
    chk("R8 fd_instr", fd_instr_o, 32'd0);
    chk("R8 fd_pc", fd_pc_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);                        // R5
    step(1, 0, 0, 16'h0003, 0, 32'd5, 32'd5, 0);                    // R1 taken
    step(0, 0, 0, 0, 0, 0, 0, 0);                                   // R6 slot
    step(1, 0, 0, 16'h0003, 0, 32'd5, 32'd6, 0);                    // R1 not taken
    step(1, 1, 0, 16'hFFFE, 0, 32'd7, 32'd8, 0);                    // R2 taken, R3 negative
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 16'h0010, 0, 32'h80000001, 32'h80000001, 0);      // R2 not taken
    step(1, 0, 1, 16'h0004, 32'h00000400, 32'd1, 32'd1, 0);         // R4 precedence
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 16'h0008, 0, 32'd9, 32'd9, 1);                    // R7 hold
    step(1, 0, 0, 16'h0008, 0, 32'd9, 32'd9, 1);
    step(1, 0, 0, 16'h0008, 0, 32'd9, 32'd9, 0);                    // deferred redirect
    step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      case ($urandom_range(0, 2))
        0:       rb = ra;
        1:       rb = ra ^ (32'h1 << $urandom_range(0, 31));
        default: rb = $urandom;
      endcase
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
           16'($urandom), {$urandom, 2'b00} & 32'hFFFF_FFFC, ra, rb, $urandom_range(0, 5) == 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule